// File: doc/BRIEF.md
# Filter Output Quantizer

This stage sits at the end of a FIR datapath. It takes the full-precision signed accumulator and turns it into a narrower signed output word. The accumulator is `IN_W` bits wide, where `IN_W` is the sample width plus the coefficient width plus ceil(log2 of the tap count). Quantization happens here once, at the output, and never inside the taps.

Two steps run in order. First the `DROP` least significant (fractional) bits are removed using one of six rounding rules. Then the integer part is cut to `OUT_W` bits, either by keeping the low bits (wrap) or by clamping to the output range (saturate). Rounding comes before the range check, so a carry out of rounding can push a value out of range.

The result is registered once, and a valid flag travels alongside it with the same delay. The output word only changes when a valid sample is accepted.

Top module: `fxp_out_quant`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier, and `out_data` carries the result for the sample presented on that earlier clock (one register of latency).
- R2: When `in_valid` is low at a clock edge, `out_data` keeps its previous value.
- R3: `round_sel` = 0 rounds toward minus infinity (floor).
- R4: `round_sel` = 1 rounds toward plus infinity (ceiling).
- R5: `round_sel` = 2 rounds to the nearest value, and an exact half goes to the even result (convergent).
- R6: `round_sel` = 3 rounds to the nearest value, and an exact half goes toward plus infinity.
- R7: `round_sel` = 4 rounds to the nearest value, and an exact half goes away from zero.
- R8: `round_sel` = 5 rounds toward zero.
- R9: `round_sel` codes 6 and 7 behave exactly as floor.
- R10: The overflow check uses the rounded value, so a rounding carry past the most positive code, or a rounding step below the most negative code, counts as overflow.
- R11: With `sat_en` = 1, an out-of-range rounded value becomes the most positive code (0 followed by ones) or the most negative code (1 followed by zeros), according to its sign. A non-negative input never gives a negative output.
- R12: With `sat_en` = 0, the output is the low `OUT_W` bits of the rounded value, in two's complement.
- R13: While `rst_n` is low (active-low, asynchronous), `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | IN_W | Full-precision signed accumulator value |
| in_valid | input | 1 | Qualifies in_data |
| round_sel | input | 3 | Rounding rule: 0 floor, 1 ceiling, 2 convergent, 3 nearest, 4 round half away, 5 toward zero, 6/7 floor |
| sat_en | input | 1 | 1 saturates on overflow, 0 wraps |
| out_data | output | OUT_W | Quantized signed output |
| out_valid | output | 1 | Qualifies out_data |

## Verification
Rounding and overflow handling can act on the same sample. This happens when an input just below the top or bottom of the output range sits on or past a rounding tie, so that the rounding increment itself carries the value out of range. The bench provokes this in two ways. It sweeps every input code of a small configuration under every rounding code and both overflow modes. It also runs directed samples at +15.5 and -16.5 output units. Each result is judged against an arithmetic model that rounds first and only then saturates or wraps.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

    typedef enum logic [2:0] {
        RND_FLOOR = 3'd0,
        RND_CEIL  = 3'd1,
        RND_CONV  = 3'd2,
        RND_NEAR  = 3'd3,
        RND_AWAY  = 3'd4,
        RND_ZERO  = 3'd5
    } rnd_mode_e;

endpackage

// File: rtl/fxq_round.sv
// Removes DROP fractional bits with a selectable rule; the result is one
// bit wider than the kept part so that the increment never overflows.
module fxq_round
    import fxq_pkg::*;
#(
    parameter int IN_W = 24,
    parameter int DROP = 8
) (
    input  logic [IN_W-1:0]    din,
    input  logic [2:0]         mode,
    output logic [IN_W-DROP:0] dout
);

    localparam int KEEP = IN_W - DROP;

    logic [KEEP-1:0] base;
    logic            half;
    logic            rest;
    logic            any_frac;
    logic            neg;
    logic            inc;

    assign base = din[IN_W-1:DROP];
    assign half = din[DROP-1];
    assign neg  = din[IN_W-1];

    generate
        if (DROP >= 2) begin : g_rest
            assign rest = |din[DROP-2:0];
        end else begin : g_norest
            assign rest = 1'b0;
        end
    endgenerate

    assign any_frac = half | rest;

    always_comb begin
        case (mode)
            RND_CEIL: inc = any_frac;
            RND_CONV: inc = half & (rest | base[0]);
            RND_NEAR: inc = half;
            RND_AWAY: inc = half & (rest | ~neg);
            RND_ZERO: inc = neg & any_frac;
            default:  inc = 1'b0;
        endcase
    end

    assign dout = {base[KEEP-1], base} + {{KEEP{1'b0}}, inc};

endmodule

// File: rtl/fxq_clamp.sv
// Narrows a signed value to OUT_W bits by wrap-around or saturation.
module fxq_clamp #(
    parameter int RW    = 17,
    parameter int OUT_W = 12
) (
    input  logic [RW-1:0]    din,
    input  logic             sat_en,
    output logic [OUT_W-1:0] dout
);

    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (RW > OUT_W) begin : g_narrow
            logic [RW-OUT_W:0] upper;
            logic              ovf;
            assign upper = din[RW-1:OUT_W-1];
            assign ovf   = ~((&upper) | ~(|upper));
            always_comb begin
                if (sat_en && ovf) begin
                    dout = din[RW-1] ? NEG_MAX : POS_MAX;
                end else begin
                    dout = din[OUT_W-1:0];
                end
            end
        end else begin : g_pass
            logic sat_unused;
            assign sat_unused = sat_en;
            assign dout       = din[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fxp_out_quant.sv
// Output quantizer: round, then wrap or saturate, then one register stage.
module fxp_out_quant
    import fxq_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int DROP  = 8,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    input  logic [2:0]       round_sel,
    input  logic             sat_en,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid
);

    localparam int RW = IN_W - DROP + 1;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] dat;
    } stage_t;

    stage_t           st_d;
    stage_t           st_q;
    logic [RW-1:0]    rnd_val;
    logic [OUT_W-1:0] nar_val;

    fxq_round #(
        .IN_W (IN_W),
        .DROP (DROP)
    ) u_round (
        .din  (in_data),
        .mode (round_sel),
        .dout (rnd_val)
    );

    fxq_clamp #(
        .RW    (RW),
        .OUT_W (OUT_W)
    ) u_clamp (
        .din    (rnd_val),
        .sat_en (sat_en),
        .dout   (nar_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.dat = nar_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.dat;
    assign out_valid = st_q.vld;

endmodule

// File: rtl/fxq_checker.sv
module fxq_checker #(
    parameter int IN_W  = 24,
    parameter int DROP  = 8,
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  in_data,
    input logic             in_valid,
    input logic [2:0]       round_sel,
    input logic             sat_en,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (out_valid == $past(in_valid)));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(in_valid)) |-> $stable(out_data));

    assert_sat_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && sat_en && !in_data[IN_W-1])) |-> !out_data[OUT_W-1]);

    assert_wrap_floor_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(in_valid && !sat_en && (round_sel == 3'd0)))
            |-> (out_data == $past(in_data[DROP+OUT_W-1:DROP])));

endmodule

bind fxp_out_quant fxq_checker #(
    .IN_W  (IN_W),
    .DROP  (DROP),
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .round_sel (round_sel),
    .sat_en    (sat_en),
    .out_data  (out_data),
    .out_valid (out_valid)
);

// File: tb/sim_fxp_out_quant.sv
`timescale 1ns/1ps
module sim_fxp_out_quant;

    localparam int IN_W  = 10;
    localparam int DROP  = 3;
    localparam int OUT_W = 5;
    localparam int OMAX  = (1 << (OUT_W - 1)) - 1;
    localparam int OMIN  = -(1 << (OUT_W - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             in_valid = 1'b0;
    logic [2:0]       round_sel = '0;
    logic             sat_en = 1'b0;
    logic [OUT_W-1:0] out_data;
    logic             out_valid;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    fxp_out_quant #(
        .IN_W  (IN_W),
        .DROP  (DROP),
        .OUT_W (OUT_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .round_sel (round_sel),
        .sat_en    (sat_en),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    function automatic string mode_tag(int m);
        case (m)
            0:       return "R3";
            1:       return "R4";
            2:       return "R5";
            3:       return "R6";
            4:       return "R7";
            5:       return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int ref_q(int x, int m, bit sat);
        int fl;
        int fr;
        int hv;
        int r;
        fl = x >>> DROP;
        fr = x - fl * (1 << DROP);
        hv = 1 << (DROP - 1);
        case (m)
            1:       r = fl + ((fr != 0) ? 1 : 0);
            2:       r = fl + (((fr > hv) || ((fr == hv) && (fl % 2 != 0))) ? 1 : 0);
            3:       r = fl + ((fr >= hv) ? 1 : 0);
            4:       r = fl + (((fr > hv) || ((fr == hv) && (x >= 0))) ? 1 : 0);
            5:       r = fl + (((x < 0) && (fr != 0)) ? 1 : 0);
            default: r = fl;
        endcase
        if (sat) begin
            if (r > OMAX) r = OMAX;
            if (r < OMIN) r = OMIN;
        end else begin
            r = r & ((1 << OUT_W) - 1);
            if (r > OMAX) r = r - (1 << OUT_W);
        end
        return r;
    endfunction

    function automatic int got_val();
        return int'($signed(out_data));
    endfunction

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(int x, int m, bit sat);
        @(negedge clk);
        in_data   = IN_W'(x);
        in_valid  = 1'b1;
        round_sel = 3'(m);
        sat_en    = sat;
        @(negedge clk);
    endtask

    initial begin
        // R13: reset state
        @(negedge clk);
        check("R13 valid", int'(out_valid), 0);
        check("R13 data", got_val(), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // full sweep: every input, every rounding code, both overflow modes
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 8; m++) begin
                for (int x = -(1 << (IN_W - 1)); x < (1 << (IN_W - 1)); x++) begin
                    apply(x, m, bit'(s));
                    check("R1 valid", int'(out_valid), 1);
                    if (s == 1) check({mode_tag(m), "/R11 sat"}, got_val(), ref_q(x, m, 1'b1));
                    else        check({mode_tag(m), "/R12 wrap"}, got_val(), ref_q(x, m, 1'b0));
                end
            end
        end

        // R10: rounding carry crosses the range limits (+15.5 and -16.5)
        apply(124, 3, 1'b1);
        check("R10 sat carry up", got_val(), 15);
        apply(124, 3, 1'b0);
        check("R10 wrap carry up", got_val(), -16);
        apply(-132, 4, 1'b1);
        check("R10 sat step down", got_val(), -16);
        apply(-132, 4, 1'b0);
        check("R10 wrap step down", got_val(), 15);
        apply(-132, 2, 1'b1);
        check("R10 convergent tie stays", got_val(), -16);

        // R2: output held while in_valid is low
        apply(40, 0, 1'b1);
        check("R2 setup", got_val(), 5);
        in_data   = IN_W'(-300);
        in_valid  = 1'b0;
        round_sel = 3'd1;
        @(negedge clk);
        check("R1 valid drop", int'(out_valid), 0);
        check("R2 hold", got_val(), 5);
        @(negedge clk);
        check("R2 hold again", got_val(), 5);

        // R13: asynchronous reset clears again
        rst_n = 1'b0;
        #1;
        check("R13 re-reset valid", int'(out_valid), 0);
        check("R13 re-reset data", got_val(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule